// File: doc/BRIEF.md
# Special Register Access Guard

The block sits beside the decoder of a processor pipeline. It handles the instructions that move values to and from special registers. It accepts the raw 10-bit register-number field of such an instruction, whose two 5-bit halves arrive swapped, and rebuilds the real register number. It looks that number up in a constant access table and grades the access against the current machine state. The machine state is given by a guest bit and a problem-state (user) bit. The block then reports one of three results: a grant, a privilege exception, or an illegal-register flag.

A second number space holds the performance-monitor registers and is selected by its own input. Some registers have a guest copy, and an access made in guest supervisor state is redirected to that copy. The result includes the physical index that the access lands on.

A small bank of example registers stands behind the table, so that granted reads and writes can be followed end to end. One register in the bank uses clear-on-write semantics. All results are registered and appear one clock after the request.

Top module: `spr_access_guard`

## Requirements
- R1: `regnum_o` equals `{field_i[4:0], field_i[9:5]}` of the request. For example, register 22 arrives as `field_i = 10'b10110_00000` and register 287 arrives as `10'b11111_01000`.
- R2: Every result output appears on the first rising clock edge after a cycle with `valid_i` high, and `valid_o` is high only then. When `valid_o` is low, `grant_o`, `priv_exc_o`, `illegal_o` and `rdata_o` are all zero, including after reset.
- R3: With `pmr_i = 0`, the implemented table is as follows:
  - 22: supervisor, index 0.
  - 287: supervisor read-only, index 1, reads the `VER_ID` parameter.
  - 256: user, index 2.
  - 259: user read-only, index 2.
  - 61: supervisor, index 3, guest copy at index 4.
  - 383: hypervisor, index 4.
  - 304: hypervisor, index 5.
  - 305: hypervisor read-only, index 5.
  - 306: hypervisor write-only, index 6.
  - 336: hypervisor read/clear, index 7.
  - 338: hypervisor-write / supervisor-read, index 8.

  Any number not in the table for its space raises `illegal_o` alone. At most one of `grant_o`, `priv_exc_o` and `illegal_o` is high. Every denied access to a number in the table raises `priv_exc_o`.
- R4: A user register is granted for reads and writes in every state. A user read-only register is granted for reads in every state and denies writes.
- R5: Supervisor and supervisor read-only registers are granted when `prob_i = 0`, whatever the value of `guest_i`. The read-only class denies writes.
- R6: With `HYP_PRESENT = 1`, the hypervisor classes are granted only when `guest_i = 0` and `prob_i = 0`. Within that state, the read-only class denies writes and the write-only class denies reads.
- R7: With `HYP_PRESENT = 0`, every hypervisor class is granted whenever `prob_i = 0`, and no redirect takes place.
- R8: A granted write to the read/clear register clears exactly the bits that are set in `wdata_i` and keeps all other bits. That register resets to all ones.
- R9: The hypervisor-write / supervisor-read register grants reads whenever `prob_i = 0`. It grants writes only in hypervisor state.
- R10: With `HYP_PRESENT = 1`, an access to register 61 with `guest_i = 1` and `prob_i = 0` is redirected to index 4. In other states it goes to index 3. `target_o` shows the index that was used.
- R11: With `pmr_i = 1`, the implemented table is:
  - 400: supervisor global control, index 9.
  - 384: user read-only alias of 400.
  - 16: supervisor counter, index 10.
  - 0: user read-only alias of 16.

  Any access from user state to 400 or 16 raises `priv_exc_o`.
- R12: Bank state changes only on a granted write. `rdata_o` carries the value of the target register on a granted read and is zero otherwise. Reset restores every register to its initial value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| pmr_i | input | 1 | Selects the performance-monitor number space |
| field_i | input | 10 | Raw register-number field, halves swapped |
| write_i | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| guest_i | input | 1 | Machine-state guest bit |
| prob_i | input | 1 | Machine-state problem (user) bit |
| wdata_i | input | 32 | Source operand for writes |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| regnum_o | output | 10 | Rebuilt register number |
| target_o | output | 4 | Physical index reached, after any redirect |
| grant_o | output | 1 | Access allowed |
| priv_exc_o | output | 1 | Privilege exception |
| illegal_o | output | 1 | Number not implemented |
| rdata_o | output | 32 | Read data on a granted read, else zero |

## Verification
The bench goes after swap order, since a design that skipped the unswap would flag register 22 as illegal. It sweeps each class in the guest-supervisor, hypervisor and user states. A design that tested only the problem-state bit would let guest code write hypervisor registers. It also sends denied writes to aliased registers, then reads the registers back to show that the value did not change. It drives the read/clear register with a mask and checks the remaining bits, which a design loading the operand would get wrong. It checks the guest-copy redirect from both sides of the state. It also runs a second instance built without the hypervisor category, where a design that kept the guest test would deny supervisor code.

// File: rtl/spr_guard_pkg.sv
package spr_guard_pkg;
  localparam int NUM_W  = 10;
  localparam int HALF_W = NUM_W / 2;
  localparam int NREG   = 11;
  localparam int IDX_W  = $clog2(NREG);

  typedef enum logic [3:0] {
    ACC_USER,
    ACC_USER_RO,
    ACC_SUP,
    ACC_SUP_RO,
    ACC_HYP,
    ACC_HYP_RO,
    ACC_HYP_WO,
    ACC_HYP_RCLR,
    ACC_HYP_WGR
  } acc_class_e;

  typedef struct packed {
    logic             hit;
    acc_class_e       cls;
    logic [IDX_W-1:0] idx;
    logic             redir;
    logic [IDX_W-1:0] gidx;
  } map_ent_t;

  function automatic map_ent_t mk(acc_class_e c, int i, logic r, int g);
    map_ent_t e;
    e.hit   = 1'b1;
    e.cls   = c;
    e.idx   = IDX_W'(i);
    e.redir = r;
    e.gidx  = IDX_W'(g);
    return e;
  endfunction

  // key = {pmr space, register number}
  function automatic map_ent_t map_lookup(logic pmr, logic [NUM_W-1:0] num);
    map_ent_t e;
    e = '0;
    case ({pmr, num})
      {1'b0, 10'd22}:  e = mk(ACC_SUP,      0,  1'b0, 0);
      {1'b0, 10'd287}: e = mk(ACC_SUP_RO,   1,  1'b0, 0);
      {1'b0, 10'd256}: e = mk(ACC_USER,     2,  1'b0, 0);
      {1'b0, 10'd259}: e = mk(ACC_USER_RO,  2,  1'b0, 0);
      {1'b0, 10'd61}:  e = mk(ACC_SUP,      3,  1'b1, 4);
      {1'b0, 10'd383}: e = mk(ACC_HYP,      4,  1'b0, 0);
      {1'b0, 10'd304}: e = mk(ACC_HYP,      5,  1'b0, 0);
      {1'b0, 10'd305}: e = mk(ACC_HYP_RO,   5,  1'b0, 0);
      {1'b0, 10'd306}: e = mk(ACC_HYP_WO,   6,  1'b0, 0);
      {1'b0, 10'd336}: e = mk(ACC_HYP_RCLR, 7,  1'b0, 0);
      {1'b0, 10'd338}: e = mk(ACC_HYP_WGR,  8,  1'b0, 0);
      {1'b1, 10'd400}: e = mk(ACC_SUP,      9,  1'b0, 0);
      {1'b1, 10'd384}: e = mk(ACC_USER_RO,  9,  1'b0, 0);
      {1'b1, 10'd16}:  e = mk(ACC_SUP,      10, 1'b0, 0);
      {1'b1, 10'd0}:   e = mk(ACC_USER_RO,  10, 1'b0, 0);
      default:         e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/spr_num_unswap.sv
module spr_num_unswap #(
  parameter int W = 10
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] num_o
);
  localparam int H = W / 2;
  assign num_o = {raw_i[H-1:0], raw_i[W-1:H]};
endmodule

// File: rtl/spr_class_rom.sv
module spr_class_rom
  import spr_guard_pkg::*;
(
  input  logic             pmr_i,
  input  logic [NUM_W-1:0] num_i,
  output map_ent_t         ent_o
);
  always_comb ent_o = map_lookup(pmr_i, num_i);
endmodule

// File: rtl/spr_priv_check.sv
module spr_priv_check
  import spr_guard_pkg::*;
#(
  parameter bit HYP_PRESENT = 1'b1
) (
  input  map_ent_t         ent_i,
  input  logic             write_i,
  input  logic             guest_i,
  input  logic             prob_i,
  output logic             grant_o,
  output logic             priv_exc_o,
  output logic             illegal_o,
  output logic [IDX_W-1:0] target_o
);
  logic sup_ok, hyp_ok, gsup, ok;

  assign sup_ok = !prob_i;

  generate
    if (HYP_PRESENT) begin : g_hyp
      assign hyp_ok = !guest_i && !prob_i;
      assign gsup   = guest_i && !prob_i;
    end else begin : g_nohyp
      assign hyp_ok = !prob_i;
      assign gsup   = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (ent_i.cls)
      ACC_USER:     ok = 1'b1;
      ACC_USER_RO:  ok = !write_i;
      ACC_SUP:      ok = sup_ok;
      ACC_SUP_RO:   ok = sup_ok && !write_i;
      ACC_HYP:      ok = hyp_ok;
      ACC_HYP_RO:   ok = hyp_ok && !write_i;
      ACC_HYP_WO:   ok = hyp_ok && write_i;
      ACC_HYP_RCLR: ok = hyp_ok;
      ACC_HYP_WGR:  ok = write_i ? hyp_ok : sup_ok;
      default:      ok = 1'b0;
    endcase
  end

  assign illegal_o  = !ent_i.hit;
  assign grant_o    = ent_i.hit && ok;
  assign priv_exc_o = ent_i.hit && !ok;
  assign target_o   = !ent_i.hit ? '0 :
                      (ent_i.redir && gsup) ? ent_i.gidx : ent_i.idx;
endmodule

// File: rtl/spr_reg_bank.sv
module spr_reg_bank #(
  parameter int                    NREG   = 11,
  parameter int                    DW     = 32,
  parameter int                    IDX_W  = 4,
  parameter logic [NREG*DW-1:0]    INIT   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q[i] <= INIT[i*DW +: DW];
      end else if (we_i && idx_i == IDX_W'(i)) begin
        q[i] <= clr_i ? (q[i] & ~wdata_i) : wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (idx_i == IDX_W'(i)) rdata_o = q[i];
    end
  end
endmodule

// File: rtl/spr_access_guard.sv
module spr_access_guard
  import spr_guard_pkg::*;
#(
  parameter bit          HYP_PRESENT = 1'b1,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] VER_ID      = 32'h8021_0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              pmr_i,
  input  logic [NUM_W-1:0]  field_i,
  input  logic              write_i,
  input  logic              guest_i,
  input  logic              prob_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              valid_o,
  output logic [NUM_W-1:0]  regnum_o,
  output logic [IDX_W-1:0]  target_o,
  output logic              grant_o,
  output logic              priv_exc_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int VER_IDX  = 1;
  localparam int RCLR_IDX = 7;

  function automatic logic [NREG*DATA_W-1:0] init_vals();
    logic [NREG*DATA_W-1:0] v;
    v = '0;
    v[VER_IDX*DATA_W +: DATA_W]  = DATA_W'(VER_ID);
    v[RCLR_IDX*DATA_W +: DATA_W] = '1;
    return v;
  endfunction

  localparam logic [NREG*DATA_W-1:0] INIT = init_vals();

  logic [NUM_W-1:0]  num;
  map_ent_t          ent;
  logic              grant, priv_exc, illegal;
  logic [IDX_W-1:0]  target;
  logic [DATA_W-1:0] bank_rd;
  logic              bank_we, bank_clr;

  spr_num_unswap #(.W(NUM_W)) u_unswap (
    .raw_i (field_i),
    .num_o (num)
  );

  spr_class_rom u_rom (
    .pmr_i (pmr_i),
    .num_i (num),
    .ent_o (ent)
  );

  spr_priv_check #(.HYP_PRESENT(HYP_PRESENT)) u_chk (
    .ent_i      (ent),
    .write_i    (write_i),
    .guest_i    (guest_i),
    .prob_i     (prob_i),
    .grant_o    (grant),
    .priv_exc_o (priv_exc),
    .illegal_o  (illegal),
    .target_o   (target)
  );

  assign bank_we  = valid_i && grant && write_i;
  assign bank_clr = (ent.cls == ACC_HYP_RCLR);

  spr_reg_bank #(
    .NREG  (NREG),
    .DW    (DATA_W),
    .IDX_W (IDX_W),
    .INIT  (INIT)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bank_we),
    .clr_i   (bank_clr),
    .idx_i   (target),
    .wdata_i (wdata_i),
    .rdata_o (bank_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      regnum_o   <= '0;
      target_o   <= '0;
      grant_o    <= 1'b0;
      priv_exc_o <= 1'b0;
      illegal_o  <= 1'b0;
      rdata_o    <= '0;
    end else begin
      valid_o    <= valid_i;
      regnum_o   <= valid_i ? num : '0;
      target_o   <= valid_i ? target : '0;
      grant_o    <= valid_i && grant;
      priv_exc_o <= valid_i && priv_exc;
      illegal_o  <= valid_i && illegal;
      rdata_o    <= (valid_i && grant && !write_i) ? bank_rd : '0;
    end
  end
endmodule

// File: rtl/spr_access_guard_chk.sv
module spr_access_guard_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        write_i,
  input logic [9:0]  field_i,
  input logic        valid_o,
  input logic [9:0]  regnum_o,
  input logic        grant_o,
  input logic        priv_exc_o,
  input logic        illegal_o,
  input logic [31:0] rdata_o
);
  // R3
  excl_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, priv_exc_o, illegal_o}));

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(grant_o || priv_exc_o || illegal_o) && rdata_o == '0);

  // R1
  unswap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> regnum_o == {$past(field_i[4:0]), $past(field_i[9:5])});

  // R12
  no_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && write_i |=> rdata_o == '0);

  // R12
  denied_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !grant_o |-> rdata_o == '0);
endmodule

bind spr_access_guard spr_access_guard_chk u_guard_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .write_i    (write_i),
  .field_i    (field_i),
  .valid_o    (valid_o),
  .regnum_o   (regnum_o),
  .grant_o    (grant_o),
  .priv_exc_o (priv_exc_o),
  .illegal_o  (illegal_o),
  .rdata_o    (rdata_o)
);

// File: tb/test_spr_access_guard.sv
module test_spr_access_guard;
  localparam logic [31:0] VER = 32'h8021_0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, pmr = 1'b0, wr = 1'b0, guest = 1'b0, prob = 1'b0;
  logic [9:0]  field = '0;
  logic [31:0] wdata = '0;

  logic        v_o, g_o, p_o, i_o;
  logic [9:0]  n_o;
  logic [3:0]  t_o;
  logic [31:0] d_o;
  logic        nv_o, ng_o, np_o, ni_o;
  logic [9:0]  nn_o;
  logic [3:0]  nt_o;
  logic [31:0] nd_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spr_access_guard #(.HYP_PRESENT(1'b1), .VER_ID(VER)) i_spr_access_guard (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pmr_i(pmr), .field_i(field),
    .write_i(wr), .guest_i(guest), .prob_i(prob), .wdata_i(wdata),
    .valid_o(v_o), .regnum_o(n_o), .target_o(t_o), .grant_o(g_o),
    .priv_exc_o(p_o), .illegal_o(i_o), .rdata_o(d_o));

  spr_access_guard #(.HYP_PRESENT(1'b0), .VER_ID(VER)) i_spr_access_guard_nohyp (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pmr_i(pmr), .field_i(field),
    .write_i(wr), .guest_i(guest), .prob_i(prob), .wdata_i(wdata),
    .valid_o(nv_o), .regnum_o(nn_o), .target_o(nt_o), .grant_o(ng_o),
    .priv_exc_o(np_o), .illegal_o(ni_o), .rdata_o(nd_o));

  typedef struct packed {
    logic [3:0]  req;
    logic        pmr;
    logic [9:0]  num;
    logic        wr;
    logic        g;
    logic        p;
    logic [31:0] wd;
    logic        eg;
    logic        ep;
    logic        ei;
    logic [3:0]  et;
    logic [31:0] erd;
  } vec_t;

  localparam int NV = 42;
  // requirement tags per row: R3 R4 R5 R6 R8 R9 R10 R11 R12
  localparam vec_t VECS [NV] = '{
    '{4'd5, 1'b0, 10'd287, 1'b0, 1'b0, 1'b1, 32'h0,      1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd5, 1'b0, 10'd287, 1'b0, 1'b1, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd1, VER},
    '{4'd5, 1'b0, 10'd287, 1'b1, 1'b0, 1'b0, 32'h0,      1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd5, 1'b0, 10'd22,  1'b1, 1'b1, 1'b0, 32'h1234,   1'b1, 1'b0, 1'b0, 4'd0, 32'h0},
    '{4'd5, 1'b0, 10'd22,  1'b0, 1'b0, 1'b1, 32'h0,      1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd12,1'b0, 10'd22,  1'b0, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd0, 32'h1234},
    '{4'd4, 1'b0, 10'd256, 1'b1, 1'b0, 1'b1, 32'hA5A5,   1'b1, 1'b0, 1'b0, 4'd2, 32'h0},
    '{4'd4, 1'b0, 10'd259, 1'b0, 1'b1, 1'b1, 32'h0,      1'b1, 1'b0, 1'b0, 4'd2, 32'hA5A5},
    '{4'd4, 1'b0, 10'd259, 1'b1, 1'b0, 1'b0, 32'hFFFF,   1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd10,1'b0, 10'd61,  1'b1, 1'b1, 1'b0, 32'hDEAD,   1'b1, 1'b0, 1'b0, 4'd4, 32'h0},
    '{4'd10,1'b0, 10'd61,  1'b1, 1'b0, 1'b0, 32'hBEEF,   1'b1, 1'b0, 1'b0, 4'd3, 32'h0},
    '{4'd10,1'b0, 10'd61,  1'b0, 1'b1, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd4, 32'hDEAD},
    '{4'd6, 1'b0, 10'd383, 1'b0, 1'b1, 1'b0, 32'h0,      1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd10,1'b0, 10'd383, 1'b0, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd4, 32'hDEAD},
    '{4'd10,1'b0, 10'd61,  1'b0, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd3, 32'hBEEF},
    '{4'd6, 1'b0, 10'd304, 1'b1, 1'b1, 1'b0, 32'h55,     1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd6, 1'b0, 10'd304, 1'b1, 1'b0, 1'b0, 32'h55,     1'b1, 1'b0, 1'b0, 4'd5, 32'h0},
    '{4'd6, 1'b0, 10'd305, 1'b0, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd5, 32'h55},
    '{4'd6, 1'b0, 10'd305, 1'b1, 1'b0, 1'b0, 32'hFF,     1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd12,1'b0, 10'd304, 1'b0, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd5, 32'h55},
    '{4'd6, 1'b0, 10'd306, 1'b1, 1'b0, 1'b0, 32'h77,     1'b1, 1'b0, 1'b0, 4'd6, 32'h0},
    '{4'd6, 1'b0, 10'd306, 1'b0, 1'b0, 1'b0, 32'h0,      1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd8, 1'b0, 10'd336, 1'b1, 1'b0, 1'b0, 32'hF0,     1'b1, 1'b0, 1'b0, 4'd7, 32'h0},
    '{4'd8, 1'b0, 10'd336, 1'b0, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd7, 32'hFFFF_FF0F},
    '{4'd8, 1'b0, 10'd336, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd8, 1'b0, 10'd336, 1'b0, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd7, 32'hFFFF_FF0F},
    '{4'd9, 1'b0, 10'd338, 1'b1, 1'b1, 1'b0, 32'h9,      1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd9, 1'b0, 10'd338, 1'b1, 1'b0, 1'b0, 32'h9,      1'b1, 1'b0, 1'b0, 4'd8, 32'h0},
    '{4'd9, 1'b0, 10'd338, 1'b0, 1'b1, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd8, 32'h9},
    '{4'd9, 1'b0, 10'd338, 1'b0, 1'b0, 1'b1, 32'h0,      1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd11,1'b1, 10'd400, 1'b1, 1'b0, 1'b0, 32'h3,      1'b1, 1'b0, 1'b0, 4'd9, 32'h0},
    '{4'd11,1'b1, 10'd384, 1'b0, 1'b0, 1'b1, 32'h0,      1'b1, 1'b0, 1'b0, 4'd9, 32'h3},
    '{4'd11,1'b1, 10'd384, 1'b1, 1'b0, 1'b1, 32'h0,      1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd11,1'b1, 10'd400, 1'b0, 1'b0, 1'b1, 32'h0,      1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd11,1'b1, 10'd400, 1'b1, 1'b0, 1'b1, 32'hFF,     1'b0, 1'b1, 1'b0, 4'd0, 32'h0},
    '{4'd11,1'b1, 10'd16,  1'b1, 1'b1, 1'b0, 32'h42,     1'b1, 1'b0, 1'b0, 4'd10, 32'h0},
    '{4'd11,1'b1, 10'd0,   1'b0, 1'b0, 1'b1, 32'h0,      1'b1, 1'b0, 1'b0, 4'd10, 32'h42},
    '{4'd3, 1'b0, 10'd400, 1'b0, 1'b0, 1'b0, 32'h0,      1'b0, 1'b0, 1'b1, 4'd0, 32'h0},
    '{4'd3, 1'b0, 10'd0,   1'b0, 1'b0, 1'b0, 32'h0,      1'b0, 1'b0, 1'b1, 4'd0, 32'h0},
    '{4'd3, 1'b1, 10'd22,  1'b0, 1'b0, 1'b0, 32'h0,      1'b0, 1'b0, 1'b1, 4'd0, 32'h0},
    '{4'd12,1'b0, 10'd256, 1'b0, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd2, 32'hA5A5},
    '{4'd11,1'b1, 10'd384, 1'b0, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0, 1'b0, 4'd9, 32'h3}
  };

  function automatic logic [9:0] swap_num(logic [9:0] n);
    return {n[4:0], n[9:5]};
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a negedge; result is checked at the following negedge
  task automatic drive(logic p_s, logic [9:0] num, logic w, logic g, logic pr,
                       logic [31:0] d);
    pmr = p_s; field = swap_num(num); wr = w; guest = g; prob = pr; wdata = d;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 reset outputs", 64'({v_o, g_o, p_o, i_o, t_o, d_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      drive(v.pmr, v.num, v.wr, v.g, v.p, v.wd);
      check($sformatf("R%0d vec %0d", v.req, k),
            64'({v_o, g_o, p_o, i_o, (v.eg ? t_o : 4'd0), d_o}),
            64'({1'b1, v.eg, v.ep, v.ei, v.et, v.erd}));
      // R1: unswapped number
      check($sformatf("R1 vec %0d", k), 64'(n_o), 64'(v.num));
    end

    // R2: no strobe, no results
    @(negedge clk);
    check("R2 idle", 64'({v_o, g_o, p_o, i_o, d_o}), 64'd0);

    // R1: the two worked encodings at the raw field
    pmr = 1'b0; field = 10'b10110_00000; wr = 1'b0; guest = 1'b0; prob = 1'b0;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check("R1 raw 22", 64'({n_o, g_o}), 64'({10'd22, 1'b1}));
    field = 10'b11111_01000; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check("R1 raw 287", 64'({n_o, g_o, d_o}), 64'({10'd287, 1'b1, VER}));

    // R7: build without hypervisor category
    drive(1'b0, 10'd304, 1'b1, 1'b1, 1'b0, 32'h1);
    check("R7 hyp write guest-sup", 64'({nv_o, ng_o, np_o, ni_o}), 64'b1100);
    drive(1'b0, 10'd304, 1'b0, 1'b1, 1'b1, 32'h0);
    check("R7 hyp read user", 64'({nv_o, ng_o, np_o, ni_o}), 64'b1010);
    drive(1'b0, 10'd61, 1'b0, 1'b1, 1'b0, 32'h0);
    check("R7 no redirect", 64'({ng_o, nt_o}), 64'({1'b1, 4'd3}));
    drive(1'b0, 10'd306, 1'b0, 1'b1, 1'b0, 32'h0);
    check("R7 write-only read", 64'({ng_o, np_o}), 64'b01);
    drive(1'b0, 10'd305, 1'b0, 1'b1, 1'b0, 32'h0);
    check("R7 hyp-ro read guest-sup", 64'({ng_o, nd_o}), 64'({1'b1, 32'h1}));

    // R12: reset restores initial contents
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 10'd22, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R12 reset clears", 64'({g_o, d_o}), 64'({1'b1, 32'h0}));
    // R8: read/clear register back to all ones
    drive(1'b0, 10'd336, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R8 reset ones", 64'({g_o, d_o}), 64'({1'b1, 32'hFFFF_FFFF}));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule